// File: doc/BRIEF.md
# Page Load and Nonvolatile Commit Controller

This controller sits behind the bus sequence decoder of a single-data-line memory. The decoder reports each completed bus cycle as a one-clock event: a reset sequence, an address load with its address, a data-bit write with the bit value, or a read cycle. After an address load, data bits are shifted most significant bit first into a page buffer of `PAGE_BYTES` bytes. The buffer is filled starting at the page offset given by the address, and the fill position wraps inside the page.

The controller starts a commit only when it sees a read, then a write of 1, then a read, and only if four conditions hold. A reset sequence must have armed the write-enable latch. The load must have ended on a byte boundary with at least one byte loaded. The pattern must not be broken. The protection unit must allow the write. The commit scans the buffer in ascending offset order and issues one array write per clock for each byte that was loaded. It holds busy for a parameterised number of clocks, `COMMIT_CYCLES`, which must be at least `PAGE_BYTES`. While busy is high, the level returned on the data line reads 0. The latch clears when the commit finishes and after any invalid sequence.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, busy is 0, the status line reads 1, no array write occurs, and the write-enable latch is clear.
- R2: Each eight consecutive data-bit writes form one byte, first bit in bit 7, stored at the address's low offset bits, with the offset rising by one per byte.
- R3: The fill offset wraps from the top of the page to offset 0 of the same page, so a 33rd byte overwrites the first byte loaded.
- R4: The sequence read, write 1, read after a loaded page starts a commit; busy is 1 in the clock after the event of the second read.
- R5: A first read that arrives after a partial byte, or with no byte loaded, starts nothing and clears the latch.
- R6: Any other event where the start pattern expects a write of 1 or a read (write 0, read-read, write after the write of 1) starts nothing and clears the latch.
- R7: Only a reset sequence sets the write-enable latch; a commit attempt with the latch clear starts nothing; the latch is clear when busy falls.
- R8: Busy stays high for exactly `COMMIT_CYCLES` clocks, and the status line reads 0 while busy and 1 otherwise.
- R9: Reset sequences and address loads that arrive while busy change nothing: the commit runs to its full length, and the latch stays clear afterwards.
- R10: During the first `PAGE_BYTES` clocks of a commit, scan clock k writes buffer byte k to address page base plus k, and does so only if byte k was loaded. The page part of the address is stable throughout the commit.
- R11: If the write-allow input is 0 at the second read of the start pattern, no commit starts and the latch clears.
- R12: An address load or reset sequence discards the bytes loaded before it, so none of them is written by a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (power-up) |
| seq_reset | input | 1 | Reset sequence seen by the decoder |
| addr_load | input | 1 | Address has been fully loaded |
| addr_in | input | ADDR_W | Loaded address |
| bit_wr | input | 1 | Data-bit write cycle |
| bit_val | input | 1 | Value of the written bit |
| bit_rd | input | 1 | Read cycle |
| wr_allow | input | 1 | Protection unit permits writing this page |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| busy | output | 1 | Commit in progress |
| status_bit | output | 1 | Data-line level returned on reads |

## Verification
Valid commits are run in three forms: two bytes at an odd offset, a 33-byte load that wraps, and a load whose address is replaced part way through. Comparing the array contents after each form separates correct byte placement from wrap and discard errors. Broken sequences are also applied: a partial byte, a write 0 in place of the 1, a missing reset sequence, protection denied, and events injected during a commit. Each of these must leave busy low and the array untouched, which separates a correct latch from one that is too permissive. A behavioural model compares busy, the status line and every array write on each clock.

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
  parameter int ADDR_W        = 11,
  parameter int PAGE_BYTES    = 32,
  parameter int COMMIT_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_reset,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              bit_wr,
  input  logic              bit_val,
  input  logic              bit_rd,
  input  logic              wr_allow,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              busy,
  output logic              status_bit
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(COMMIT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_END, S_ARM, S_BUSY} state_t;

  state_t                  state;
  logic                    we_latch;
  logic [PAGE_W-1:0]       page;
  logic [OFF_W-1:0]        idx;
  logic [2:0]              bitcnt;
  logic [6:0]              shreg;
  logic [7:0]              pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]   valid;
  logic [CNT_W-1:0]        cnt;

  wire [OFF_W-1:0] scan_idx = cnt[OFF_W-1:0];
  wire             in_scan  = busy && (cnt < CNT_W'(PAGE_BYTES));
  wire             byte_end = (state == S_LOAD) && bit_wr && (bitcnt == 3'd7);

  assign busy       = (state == S_BUSY);
  assign status_bit = ~busy;
  assign mem_we     = in_scan && valid[scan_idx];
  assign mem_addr   = {page, scan_idx};
  assign mem_wdata  = pbuf[scan_idx];

  always_ff @(posedge clk)
    if (byte_end) pbuf[idx] <= {shreg, bit_val};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      we_latch <= 1'b0;
      page     <= '0;
      idx      <= '0;
      bitcnt   <= '0;
      shreg    <= '0;
      valid    <= '0;
      cnt      <= '0;
    end else if (busy) begin
      if (cnt == CNT_W'(COMMIT_CYCLES - 1)) begin
        state    <= S_IDLE;
        we_latch <= 1'b0;
        valid    <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end else if (seq_reset) begin
      we_latch <= 1'b1;
      state    <= S_IDLE;
      valid    <= '0;
    end else if (addr_load) begin
      page   <= addr_in[ADDR_W-1:OFF_W];
      idx    <= addr_in[OFF_W-1:0];
      bitcnt <= '0;
      valid  <= '0;
      state  <= S_LOAD;
    end else if (bit_wr) begin
      case (state)
        S_LOAD: begin
          shreg  <= {shreg[5:0], bit_val};
          bitcnt <= bitcnt + 3'd1;
          if (byte_end) begin
            valid[idx] <= 1'b1;
            idx        <= idx + OFF_W'(1);
          end
        end
        S_END: begin
          if (bit_val) state <= S_ARM;
          else begin
            state    <= S_IDLE;
            we_latch <= 1'b0;
          end
        end
        S_ARM: begin
          state    <= S_IDLE;
          we_latch <= 1'b0;
        end
        default: ;
      endcase
    end else if (bit_rd) begin
      case (state)
        S_LOAD: begin
          if (bitcnt == 3'd0 && |valid && we_latch) state <= S_END;
          else begin
            state    <= S_IDLE;
            we_latch <= 1'b0;
          end
        end
        S_END: begin
          state    <= S_IDLE;
          we_latch <= 1'b0;
        end
        S_ARM: begin
          if (wr_allow && we_latch) begin
            state <= S_BUSY;
            cnt   <= '0;
          end else begin
            state    <= S_IDLE;
            we_latch <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

module page_commit_chk #(
  parameter int ADDR_W = 11,
  parameter int OFF_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seq_reset,
  input logic              bit_rd,
  input logic              busy,
  input logic              we_latch,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  p_we_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  p_page_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(mem_addr[ADDR_W-1:OFF_W]));
  p_start_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bit_rd));
  p_latch_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_latch) |-> $past(seq_reset));
  p_latch_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !we_latch);
  p_reset_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && seq_reset |=> !$rose(we_latch));
endmodule

bind page_commit_ctrl page_commit_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .seq_reset(seq_reset), .bit_rd(bit_rd),
  .busy(busy), .we_latch(we_latch), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/page_commit_ctrl_tb.sv
`timescale 1ns/1ps
module page_commit_ctrl_tb;
  localparam int AW = 11, PB = 32, CYC = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic seq_reset = 0, addr_load = 0, bit_wr = 0, bit_val = 0, bit_rd = 0, wr_allow = 1;
  logic [AW-1:0] addr_in = '0;
  logic mem_we, busy, status_bit;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata;

  always #2.5 clk = ~clk;

  page_commit_ctrl #(.ADDR_W(AW), .PAGE_BYTES(PB), .COMMIT_CYCLES(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .seq_reset(seq_reset), .addr_load(addr_load),
    .addr_in(addr_in), .bit_wr(bit_wr), .bit_val(bit_val), .bit_rd(bit_rd),
    .wr_allow(wr_allow), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .status_bit(status_bit));

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic [7:0] ram [0:(1<<AW)-1];

  always @(posedge clk) if (mem_we) ram[mem_addr] <= mem_wdata;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model
  int m_state, m_latch, m_busy, m_cnt, m_page, m_idx, m_bits, m_shift;
  int m_buf [PB];
  bit m_val [PB];

  function automatic bit any_val();
    foreach (m_val[i]) if (m_val[i]) return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_latch = 0; m_busy = 0; m_cnt = 0;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (m_busy) begin
      if (m_cnt == CYC - 1) begin
        m_busy = 0; m_latch = 0; m_state = 0;
        foreach (m_val[i]) m_val[i] = 0;
      end else m_cnt++;
    end else if (seq_reset) begin
      m_latch = 1; m_state = 0;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (addr_load) begin
      m_page = (int'(addr_in) / PB) * PB; m_idx = int'(addr_in) % PB;
      m_bits = 0; m_state = 1;
      foreach (m_val[i]) m_val[i] = 0;
    end else if (bit_wr) begin
      if (m_state == 1) begin
        m_shift = ((m_shift << 1) | int'(bit_val)) & 255;
        m_bits++;
        if (m_bits == 8) begin
          m_buf[m_idx] = m_shift; m_val[m_idx] = 1;
          m_idx = (m_idx + 1) % PB; m_bits = 0;
        end
      end else if (m_state == 2 && bit_val) m_state = 3;
      else if (m_state != 0) begin m_state = 0; m_latch = 0; end
    end else if (bit_rd) begin
      if (m_state == 1 && m_bits == 0 && any_val() && m_latch != 0) m_state = 2;
      else if (m_state == 3 && wr_allow && m_latch != 0) begin m_busy = 1; m_cnt = 0; m_state = 0; end
      else if (m_state != 0) begin m_state = 0; m_latch = 0; end
    end
  end

  always @(negedge clk) if (rst_n) begin
    bit exp_we;
    exp_we = m_busy != 0 && m_cnt < PB && m_val[m_cnt % PB];
    check(busy == (m_busy != 0), "R8 busy", busy, m_busy);
    check(status_bit == (m_busy == 0), "R8 status", status_bit, m_busy == 0);
    check(mem_we == exp_we, "R10 we", mem_we, exp_we);
    if (exp_we && mem_we) begin
      check(int'(mem_addr) == m_page + m_cnt, "R10 addr", mem_addr, m_page + m_cnt);
      check(int'(mem_wdata) == m_buf[m_cnt], "R2 data", mem_wdata, m_buf[m_cnt]);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  task automatic do_reset(); seq_reset = 1; @(negedge clk); seq_reset = 0; endtask
  task automatic do_addr(input int a);
    addr_load = 1; addr_in = AW'(a); @(negedge clk); addr_load = 0;
  endtask
  task automatic wbit(input bit v); bit_wr = 1; bit_val = v; @(negedge clk); bit_wr = 0; endtask
  task automatic rd(); bit_rd = 1; @(negedge clk); bit_rd = 0; endtask
  task automatic wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
  endtask
  task automatic start_pat(); rd(); wbit(1); rd(); endtask
  task automatic run_len(output int len);
    len = 0;
    while (busy && len < 500) begin len++; @(negedge clk); end
  endtask
  task automatic idle_check(input string req);
    repeat (3) @(negedge clk);
    check(busy == 0, req, busy, 0);
  endtask

  initial begin
    int len;
    for (int i = 0; i < (1<<AW); i++) ram[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(busy == 0 && status_bit == 1 && mem_we == 0, "R1 reset", {busy, status_bit, mem_we}, 3'b010);
    rst_n = 1;
    @(negedge clk);

    // latch never set: no commit
    do_addr(11'h040); wbyte(8'h77); start_pat();
    idle_check("R7 no latch");
    check(ram[11'h040] == 8'h00, "R1 no write", ram[11'h040], 0);

    // normal commit, odd offset
    do_reset(); do_addr(11'h0A3); wbyte(8'h5A); wbyte(8'hC3); start_pat();
    check(busy == 1 && status_bit == 0, "R4 start", busy, 1);
    run_len(len);
    check(len == CYC, "R8 length", len, CYC);
    @(negedge clk);
    check(ram[11'h0A3] == 8'h5A, "R2 byte0", ram[11'h0A3], 8'h5A);
    check(ram[11'h0A4] == 8'hC3, "R2 byte1", ram[11'h0A4], 8'hC3);
    check(ram[11'h0A5] == 8'h00 && ram[11'h0A2] == 8'h00, "R10 unloaded", ram[11'h0A5], 0);

    // wrap: 33 bytes from offset 30
    do_reset(); do_addr(11'h11E);
    for (int i = 1; i <= 33; i++) wbyte(8'(i));
    start_pat(); run_len(len); @(negedge clk);
    check(ram[11'h11E] == 8'd33, "R3 overwrite", ram[11'h11E], 33);
    check(ram[11'h11F] == 8'd2, "R3 top", ram[11'h11F], 2);
    check(ram[11'h100] == 8'd3, "R3 wrap", ram[11'h100], 3);
    check(ram[11'h11D] == 8'd32, "R3 last", ram[11'h11D], 32);

    // partial byte
    do_reset(); do_addr(11'h200); wbyte(8'hEE); wbit(1); wbit(0); wbit(1); start_pat();
    idle_check("R5 partial");
    do_addr(11'h200); wbyte(8'hEE); start_pat();
    idle_check("R5 latch cleared");
    // read with no byte loaded
    do_reset(); do_addr(11'h200); start_pat();
    idle_check("R5 empty");
    check(ram[11'h200] == 8'h00, "R5 no write", ram[11'h200], 0);

    // broken patterns
    do_reset(); do_addr(11'h240); wbyte(8'h11); rd(); wbit(0); rd();
    idle_check("R6 write0");
    do_reset(); do_addr(11'h240); wbyte(8'h11); rd(); rd(); wbit(1); rd();
    idle_check("R6 read-read");
    do_reset(); do_addr(11'h240); wbyte(8'h11); rd(); wbit(1); wbit(1); rd();
    idle_check("R6 extra write");
    check(ram[11'h240] == 8'h00, "R6 no write", ram[11'h240], 0);

    // protection denied
    do_reset(); do_addr(11'h280); wbyte(8'h22); rd(); wbit(1);
    wr_allow = 0; rd(); wr_allow = 1;
    idle_check("R11 denied");
    do_addr(11'h280); wbyte(8'h22); start_pat();
    idle_check("R11 latch cleared");
    check(ram[11'h280] == 8'h00, "R11 no write", ram[11'h280], 0);

    // address reload discards bytes
    do_reset(); do_addr(11'h300); wbyte(8'hAA); do_addr(11'h308); wbyte(8'hBB); start_pat();
    run_len(len); @(negedge clk);
    check(ram[11'h300] == 8'h00, "R12 discarded", ram[11'h300], 0);
    check(ram[11'h308] == 8'hBB, "R12 kept", ram[11'h308], 8'hBB);

    // events during commit
    do_reset(); do_addr(11'h3C0); wbyte(8'h3C); start_pat();
    do_reset(); do_addr(11'h3C8);
    check(busy == 1, "R9 still busy", busy, 1);
    run_len(len);
    check(len == CYC - 2, "R9 full length", len, CYC - 2);
    @(negedge clk);
    check(ram[11'h3C0] == 8'h3C, "R9 data", ram[11'h3C0], 8'h3C);
    do_addr(11'h3D0); wbyte(8'h5C); start_pat();
    idle_check("R9 latch stays clear");
    check(ram[11'h3D0] == 8'h00, "R7 after commit", ram[11'h3D0], 0);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule